// File: doc/BRIEF.md
# I2C Master Host Register and FIFO Front-End

This block is the processor-facing half of an I2C master controller. Software reaches it through a simple 32-bit register port. It can set the control word, the target address and the four SCL high/low count values. It can turn the controller on and off and queue commands into a transmit FIFO. It drains received bytes from a receive FIFO, watches fill levels and the bus activity flag, and services interrupts. The serial bus engine sits on the other side. It takes queued command entries one at a time and returns received bytes, abort events with a cause vector, and stop-detected events.

Each command entry is nine bits wide. The low byte is data to transmit. The top bit asks the engine to read one byte instead of sending one. Configuration registers are locked while the controller is on, so the engine never sees them change during a transfer. A read-only parameter word tells software how deep both FIFOs are. Interrupt causes are collected into a raw vector, filtered by a mask, and combined into a single registered request line.

Top module: `i2c_host_frontend`

## Requirements
- R1: After reset these registers read as follows: control (0x00) reads 0x65, enable, both FIFO levels, the mask and the abort cause read 0, and `irq` is low.
- R2: A write to 0x10 queues one command entry. When write-data bit 8 is 0 the entry is {0, wdata[7:0]}. When bit 8 is 1 the entry is 0x100 and the low byte is discarded.
- R3: A write to 0x10 while the command FIFO holds TX_DEPTH entries is dropped. The level stays at TX_DEPTH and the sticky overflow cause (raw bit 3) is set.
- R4: A read of 0x10 returns the oldest received byte in bits 7:0 and removes it. Bytes come out in arrival order. A read with the receive FIFO empty returns 0 and changes nothing. A byte that arrives while the receive FIFO is full is dropped.
- R5: Offsets 0x74 and 0x78 return the command FIFO level and the receive FIFO level.
- R6: Offset 0xF4 returns TX_DEPTH-1 in bits 23:16 and RX_DEPTH-1 in bits 15:8. All other bits read 0.
- R7: Writes to control (0x00, 7 bits), target (0x04, 10 bits) and the four SCL counts (0x14, 0x18, 0x1C, 0x20, 16 bits each) take effect only while enable (0x6C bit 0) is 0. While it is 1 they are ignored.
- R8: Status (0x70) bit 0 reads the engine's busy input as sampled in the read cycle.
- R9: Raw causes (0x34) are:
  - bit 4, a level that is 1 while the command FIFO is empty;
  - bit 6, latched on an engine abort;
  - bit 9, latched on an engine stop;
  - bit 3, the overflow cause of R3.

  Offset 0x2C reads raw AND mask, where the mask is at 0x30. `irq` is high one cycle after the masked vector is nonzero.
- R10: A read of 0x40 clears the latched causes (bits 3, 6, 9) and the abort cause register.
- R11: Offset 0x80 accumulates the OR of every abort cause vector delivered with an engine abort since the last clear.
- R12: `eng_cmd_valid` is high only while enable is 1 and the command FIFO is non-empty. `eng_cmd_data` shows the oldest entry, and `eng_cmd_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| eng_cmd_valid | output | 1 | Command entry available to the engine |
| eng_cmd_data | output | 9 | Oldest command entry (bit 8 = read request) |
| eng_cmd_pop | input | 1 | Engine consumes the offered entry |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_abort | input | 1 | Engine abort event pulse |
| eng_abort_src | input | 16 | Abort cause vector, valid with `eng_abort` |
| eng_stop | input | 1 | Stop-detected event pulse |
| eng_busy | input | 1 | Bus transfer in progress |
| cfg_enable | output | 1 | Controller enable |
| cfg_ctrl | output | 7 | Control word |
| cfg_target | output | 10 | Target address |
| cfg_scl_cnt | output | 64 | Four SCL counts, register at 0x14+4i in bits 16i+15:16i |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume the register port never raises `reg_rd` and `reg_wr` in the same cycle. They also assume the engine only pulses `eng_cmd_pop` while `eng_cmd_valid` is high. The bench drives every strobe on the falling edge for exactly one cycle and keeps the two register strobes apart. It pops only after it has seen the valid flag high. It sweeps fill counts from empty through full plus overflow on a four-entry configuration. Every expected value is derived from the entry counts and from the masks written.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
  localparam logic [7:0] A_CTRL     = 8'h00;
  localparam logic [7:0] A_TARGET   = 8'h04;
  localparam logic [7:0] A_DATA     = 8'h10;
  localparam logic [7:0] A_SCL_BASE = 8'h14;
  localparam logic [7:0] A_IRQ_STAT = 8'h2C;
  localparam logic [7:0] A_IRQ_MASK = 8'h30;
  localparam logic [7:0] A_IRQ_RAW  = 8'h34;
  localparam logic [7:0] A_IRQ_CLR  = 8'h40;
  localparam logic [7:0] A_ENABLE   = 8'h6C;
  localparam logic [7:0] A_STATUS   = 8'h70;
  localparam logic [7:0] A_TX_LVL   = 8'h74;
  localparam logic [7:0] A_RX_LVL   = 8'h78;
  localparam logic [7:0] A_ABORT    = 8'h80;
  localparam logic [7:0] A_PARAM    = 8'hF4;

  localparam int NUM_SCL   = 4;
  localparam int SCL_W     = 16;
  localparam int CTRL_W    = 7;
  localparam int TARGET_W  = 10;
  localparam int CMD_W     = 9;
  localparam int IRQ_W     = 16;

  localparam int B_TX_OVER  = 3;
  localparam int B_TX_EMPTY = 4;
  localparam int B_TX_ABRT  = 6;
  localparam int B_STOP     = 9;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 7'h65;
endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic                       empty,
  output logic                       full,
  output logic                       dropped,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dropped = push && full;
  assign level   = cnt;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R3: level never exceeds the depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R3: a push into a full FIFO without a pop leaves the level unchanged
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/i2cfe_irq.sv
module i2cfe_irq import i2cfe_pkg::*; #(
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_empty,
  input  logic              over_evt,
  input  logic              abort_evt,
  input  logic [ABRT_W-1:0] abort_cause,
  input  logic              stop_evt,
  input  logic              clear,
  input  logic              mask_we,
  input  logic [IRQ_W-1:0]  mask_wdata,
  output logic [IRQ_W-1:0]  raw,
  output logic [IRQ_W-1:0]  mask,
  output logic [ABRT_W-1:0] abort_acc,
  output logic              irq
);
  logic lat_over, lat_abrt, lat_stop;

  always_comb begin
    raw             = '0;
    raw[B_TX_OVER]  = lat_over;
    raw[B_TX_EMPTY] = tx_empty;
    raw[B_TX_ABRT]  = lat_abrt;
    raw[B_STOP]     = lat_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_over  <= 1'b0;
      lat_abrt  <= 1'b0;
      lat_stop  <= 1'b0;
      abort_acc <= '0;
      mask      <= '0;
      irq       <= 1'b0;
    end else begin
      // new events win over a clear in the same cycle
      lat_over  <= over_evt  | (lat_over & ~clear);
      lat_abrt  <= abort_evt | (lat_abrt & ~clear);
      lat_stop  <= stop_evt  | (lat_stop & ~clear);
      abort_acc <= (clear ? '0 : abort_acc) | (abort_evt ? abort_cause : '0);
      if (mask_we) mask <= mask_wdata;
      irq <= |(raw & mask);
    end
  end

  // R9: an abort event is visible in the raw vector on the next cycle
  p_abort_latch_r9: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> raw[B_TX_ABRT]);

  // R10: a clear with no competing event empties the latched causes
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clear && !abort_evt && !stop_evt && !over_evt) |=>
      (!lat_abrt && !lat_stop && !lat_over && abort_acc == '0));
endmodule

// File: rtl/i2c_host_frontend.sv
module i2c_host_frontend import i2cfe_pkg::*; #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int ABRT_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [7:0]                  reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        eng_cmd_valid,
  output logic [CMD_W-1:0]            eng_cmd_data,
  input  logic                        eng_cmd_pop,
  input  logic                        eng_rx_valid,
  input  logic [7:0]                  eng_rx_data,
  input  logic                        eng_abort,
  input  logic [ABRT_W-1:0]           eng_abort_src,
  input  logic                        eng_stop,
  input  logic                        eng_busy,
  output logic                        cfg_enable,
  output logic [CTRL_W-1:0]           cfg_ctrl,
  output logic [TARGET_W-1:0]         cfg_target,
  output logic [NUM_SCL*SCL_W-1:0]    cfg_scl_cnt,
  output logic                        irq
);
  localparam int TXL_W = $clog2(TX_DEPTH+1);
  localparam int RXL_W = $clog2(RX_DEPTH+1);
  localparam logic [31:0] PARAM_WORD =
    {8'h00, 8'(TX_DEPTH-1), 8'(RX_DEPTH-1), 8'h00};

  logic             wr_data, rd_data, rd_clr, cfg_open;
  logic [CMD_W-1:0] cmd_entry, tx_head;
  logic             tx_empty, tx_full, tx_drop;
  logic [TXL_W-1:0] tx_level;
  logic [7:0]       rx_head;
  logic             rx_empty, rx_full, rx_drop;
  logic [RXL_W-1:0] rx_level;
  logic [IRQ_W-1:0] irq_raw, irq_mask;
  logic [ABRT_W-1:0] abort_acc;
  logic [31:0]      rd_mux;

  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign rd_data  = reg_rd && (reg_addr == A_DATA);
  assign rd_clr   = reg_rd && (reg_addr == A_IRQ_CLR);
  assign cfg_open = !cfg_enable;

  // a read request carries no payload byte
  assign cmd_entry = reg_wdata[8] ? CMD_W'(9'h100) : {1'b0, reg_wdata[7:0]};

  i2cfe_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_data), .wdata(cmd_entry),
    .pop(eng_cmd_pop && cfg_enable), .head(tx_head), .empty(tx_empty),
    .full(tx_full), .dropped(tx_drop), .level(tx_level)
  );

  i2cfe_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(eng_rx_valid), .wdata(eng_rx_data),
    .pop(rd_data), .head(rx_head), .empty(rx_empty),
    .full(rx_full), .dropped(rx_drop), .level(rx_level)
  );

  i2cfe_irq #(.ABRT_W(ABRT_W)) u_irq (
    .clk(clk), .rst(rst), .tx_empty(tx_empty), .over_evt(tx_drop),
    .abort_evt(eng_abort), .abort_cause(eng_abort_src), .stop_evt(eng_stop),
    .clear(rd_clr), .mask_we(reg_wr && (reg_addr == A_IRQ_MASK)),
    .mask_wdata(reg_wdata[IRQ_W-1:0]), .raw(irq_raw), .mask(irq_mask),
    .abort_acc(abort_acc), .irq(irq)
  );

  assign eng_cmd_valid = cfg_enable && !tx_empty;
  assign eng_cmd_data  = tx_head;

  // enable and the locked configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_enable <= 1'b0;
      cfg_ctrl   <= CTRL_RESET;
      cfg_target <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_ENABLE) cfg_enable <= reg_wdata[0];
      if (cfg_open && reg_addr == A_CTRL)   cfg_ctrl   <= reg_wdata[CTRL_W-1:0];
      if (cfg_open && reg_addr == A_TARGET) cfg_target <= reg_wdata[TARGET_W-1:0];
    end
  end

  // one count register per SCL phase, consecutive word offsets
  for (genvar gi = 0; gi < NUM_SCL; gi++) begin : g_scl
    localparam logic [7:0] OFS = A_SCL_BASE + 8'(4*gi);
    always_ff @(posedge clk) begin
      if (rst)
        cfg_scl_cnt[gi*SCL_W +: SCL_W] <= '0;
      else if (reg_wr && cfg_open && reg_addr == OFS)
        cfg_scl_cnt[gi*SCL_W +: SCL_W] <= reg_wdata[SCL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:     rd_mux = 32'(cfg_ctrl);
      A_TARGET:   rd_mux = 32'(cfg_target);
      A_DATA:     rd_mux = rx_empty ? 32'h0 : 32'(rx_head);
      A_IRQ_STAT: rd_mux = 32'(irq_raw & irq_mask);
      A_IRQ_MASK: rd_mux = 32'(irq_mask);
      A_IRQ_RAW:  rd_mux = 32'(irq_raw);
      A_ENABLE:   rd_mux = 32'(cfg_enable);
      A_STATUS:   rd_mux = 32'(eng_busy);
      A_TX_LVL:   rd_mux = 32'(tx_level);
      A_RX_LVL:   rd_mux = 32'(rx_level);
      A_ABORT:    rd_mux = 32'(abort_acc);
      A_PARAM:    rd_mux = PARAM_WORD;
      default: begin
        for (int i = 0; i < NUM_SCL; i++)
          if (reg_addr == A_SCL_BASE + 8'(4*i))
            rd_mux = 32'(cfg_scl_cnt[i*SCL_W +: SCL_W]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R7: locked configuration does not move on a write while enabled
  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_enable && reg_wr && (reg_addr == A_CTRL || reg_addr == A_TARGET))
      |=> ($stable(cfg_ctrl) && $stable(cfg_target)));

  // R12: the engine is never offered an entry while disabled
  p_cmd_gate_r12: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_valid |-> (cfg_enable && tx_level != '0));

  // R4: reading an empty receive FIFO returns zero
  p_rx_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_level == '0) |=> (reg_rdata == 32'h0));
endmodule

// File: tb/tb_i2c_host_frontend.sv
module tb_i2c_host_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic eng_cmd_valid, eng_cmd_pop = 0;
  logic [8:0] eng_cmd_data;
  logic eng_rx_valid = 0, eng_abort = 0, eng_stop = 0, eng_busy = 0;
  logic [7:0] eng_rx_data = 0;
  logic [15:0] eng_abort_src = 0;
  logic cfg_enable, irq;
  logic [6:0] cfg_ctrl;
  logic [9:0] cfg_target;
  logic [63:0] cfg_scl_cnt;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_host_frontend #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_data(eng_cmd_data),
    .eng_cmd_pop(eng_cmd_pop), .eng_rx_valid(eng_rx_valid),
    .eng_rx_data(eng_rx_data), .eng_abort(eng_abort),
    .eng_abort_src(eng_abort_src), .eng_stop(eng_stop), .eng_busy(eng_busy),
    .cfg_enable(cfg_enable), .cfg_ctrl(cfg_ctrl), .cfg_target(cfg_target),
    .cfg_scl_cnt(cfg_scl_cnt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_rd = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); eng_rx_valid = 1; eng_rx_data = b;
    @(negedge clk); eng_rx_valid = 0;
  endtask

  task automatic cmd_pop();
    @(negedge clk); eng_cmd_pop = 1;
    @(negedge clk); eng_cmd_pop = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_raw;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 32'h65);
    rd(8'h6C, v); chk("R1 enable", v, 0);
    rd(8'h74, v); chk("R1 txlvl", v, 0);
    rd(8'h78, v); chk("R1 rxlvl", v, 0);
    rd(8'h30, v); chk("R1 mask", v, 0);
    rd(8'h80, v); chk("R1 abort", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    // R6 parameter word
    rd(8'hF4, v); chk("R6 param", v, ((TXD-1) << 16) | ((RXD-1) << 8));

    // R7 writes land while disabled
    wr(8'h00, 32'hFFFF_FF13); rd(8'h00, v); chk("R7 ctrl open", v, 32'h13);
    wr(8'h04, 32'h0000_F2A5); rd(8'h04, v); chk("R7 target open", v, 32'h2A5);
    for (int i = 0; i < 4; i++) begin
      wr(8'(8'h14 + 4*i), 32'hABCD_0000 | (32'h100 + 7*i));
      rd(8'(8'h14 + 4*i), v); chk("R7 scl open", v, 32'h100 + 7*i);
    end
    chk("R7 scl port", 32'(cfg_scl_cnt[31:16]), 32'h107);
    wr(8'h6C, 1); rd(8'h6C, v); chk("R7 enable set", v, 1);
    wr(8'h00, 32'h7F); rd(8'h00, v); chk("R7 ctrl locked", v, 32'h13);
    wr(8'h04, 32'h3); rd(8'h04, v); chk("R7 target locked", v, 32'h2A5);
    for (int i = 0; i < 4; i++) begin
      wr(8'(8'h14 + 4*i), 32'hFFFF);
      rd(8'(8'h14 + 4*i), v); chk("R7 scl locked", v, 32'h100 + 7*i);
    end

    // R2 R3 R5 fill the command FIFO, alternating writes and read requests
    for (int k = 0; k < TXD; k++) begin
      wr(8'h10, (k % 2) ? 32'h1AB : 32'h30 + k);
      rd(8'h74, v); chk("R5 txlvl", v, k + 1);
    end
    wr(8'h10, 32'h55);
    rd(8'h74, v); chk("R3 txlvl full", v, TXD);
    rd(8'h34, v); chk("R3 over bit", v & 32'h8, 32'h8);
    for (int k = 0; k < TXD; k++) begin
      @(negedge clk);
      chk("R12 valid", {31'b0, eng_cmd_valid}, 1);
      chk("R2 entry", 32'(eng_cmd_data), (k % 2) ? 32'h100 : 32'h30 + k);
      cmd_pop();
    end
    @(negedge clk);
    chk("R12 drained", {31'b0, eng_cmd_valid}, 0);
    rd(8'h34, v); chk("R9 tx empty level", v & 32'h10, 32'h10);

    // R12 gating by enable
    wr(8'h6C, 0); wr(8'h10, 32'h77);
    @(negedge clk); chk("R12 gated", {31'b0, eng_cmd_valid}, 0);
    rd(8'h34, v); chk("R9 tx not empty", v & 32'h10, 0);
    wr(8'h6C, 1);
    @(negedge clk); chk("R12 ungated", {31'b0, eng_cmd_valid}, 1);
    chk("R12 data", 32'(eng_cmd_data), 32'h77);
    cmd_pop();

    // R4 R5 receive sweep over every fill count
    for (int n = 0; n <= RXD; n++) begin
      for (int j = 0; j < n; j++) rx_push(8'(8'h50 + 16*n + j));
      rd(8'h78, v); chk("R5 rxlvl", v, n);
      for (int j = 0; j < n; j++) begin
        rd(8'h10, v); chk("R4 rx order", v, 8'h50 + 16*n + j);
      end
      rd(8'h10, v); chk("R4 empty read", v, 0);
      rd(8'h78, v); chk("R4 empty level", v, 0);
    end
    for (int j = 0; j < RXD + 2; j++) rx_push(8'(8'hC0 + j));
    rd(8'h78, v); chk("R4 rx full", v, RXD);
    for (int j = 0; j < RXD; j++) begin
      rd(8'h10, v); chk("R4 rx drop newest", v, 8'hC0 + j);
    end

    // R8 busy flag
    eng_busy = 1; rd(8'h70, v); chk("R8 busy", v, 1);
    eng_busy = 0; rd(8'h70, v); chk("R8 idle", v, 0);

    // R11 R9 abort and stop events
    @(negedge clk); eng_abort = 1; eng_abort_src = 16'h0009;
    @(negedge clk); eng_abort = 0; eng_abort_src = 16'h8000;
    @(negedge clk); eng_abort = 1; eng_abort_src = 16'h0400;
    @(negedge clk); eng_abort = 0; eng_stop = 1;
    @(negedge clk); eng_stop = 0;
    rd(8'h80, v); chk("R11 abort acc", v, 32'h0409);
    exp_raw = 32'h258;
    rd(8'h34, v); chk("R9 raw", v, exp_raw);
    for (int m = 0; m < 6; m++) begin
      logic [31:0] mk;
      case (m)
        0: mk = 32'h010; 1: mk = 32'h040; 2: mk = 32'h200;
        3: mk = 32'h008; 4: mk = 32'h000; default: mk = 32'h0A7;
      endcase
      wr(8'h30, mk);
      @(negedge clk);
      rd(8'h2C, v); chk("R9 masked", v, exp_raw & mk);
      chk("R9 irq", {31'b0, irq}, ((exp_raw & mk) != 0) ? 1 : 0);
    end

    // R10 clear
    wr(8'h30, 32'h248);
    rd(8'h40, v);
    rd(8'h34, v); chk("R10 raw after clear", v, 32'h010);
    rd(8'h80, v); chk("R10 abort cleared", v, 0);
    @(negedge clk);
    chk("R10 irq low", {31'b0, irq}, 0);

    done = 1;
    finish_run();
  end
endmodule